// File: doc/BRIEF.md
# Address Latch with Step Unit

This block holds a CPU address in a 16-bit register that captures its value from a shared, bidirectional internal bus. The held value passes through a step unit. The step unit can add or subtract a step of one, or pass the value through unchanged. It can also keep its counting inside the low six bits, which suits a refresh-style counter. A separate control forces its result to zero, which is used to clear the program counter or the refresh counter.

Two select inputs choose what appears on the address output: either the step result or the raw held value. A flag reports when the address output equals one. When its output enable is high, the block drives the step result back onto the internal bus. This lets a sequencer increment a register by looping the result into the hold register in the same cycle.

The sequencer, the register file and the external memory interface lie outside this block.

Top module: `addr_latch_inc`

## Requirements
- R1: A synchronous active-high `rst` at a rising clock edge sets the held value to 0x0000.
- R2: At a rising edge with `ld_en` high, the held value takes the value present on `ibus`.
- R3: At a rising edge with `ld_en` low, the held value stays unchanged, whatever is on `ibus`.
- R4: The step is `step_en` (1 or 0). With `step_down` low the step result is held value plus step. With `step_down` high it is held value minus step. With `step_en` low the result equals the held value.
- R5: Full-width stepping wraps modulo 2^16: 0xFFFF+1 gives 0x0000, 0x0000-1 gives 0xFFFF, and 0xFFFF-1 gives 0xFFFE.
- R6: With `wrap_low` high, only bits [5:0] step and wrap modulo 64, and bits [15:6] equal the held value. For example, 0x12BF+1 gives 0x1280 and 0x12C0-1 gives 0x12FF.
- R7: With `force_zero` high, the step result is 0x0000. This control wins over `wrap_low` and over the step.
- R8: `addr_out` equals the step result while `sel_step` is high. Otherwise it equals the raw held value, whether `sel_hold` is high or both selects are low.
- R9: With `bus_oe` high the block drives the step result onto `ibus`. With `bus_oe` low it releases `ibus` to high impedance, so another agent can drive the bus and be loaded without contention.
- R10: `addr_is_one` is high exactly when `addr_out` equals 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load held value from the internal bus |
| bus_oe | input | 1 | Drive the step result onto the internal bus |
| sel_step | input | 1 | Show the step result on the address output |
| sel_hold | input | 1 | Show the raw held value on the address output |
| step_en | input | 1 | Step size: 1 when high, 0 when low |
| step_down | input | 1 | Subtract the step when high, add it when low |
| wrap_low | input | 1 | Confine stepping to bits [5:0] |
| force_zero | input | 1 | Force the step result to zero |
| ibus | inout | 16 | Shared tri-state internal bus |
| addr_out | output | 16 | Selected address |
| addr_is_one | output | 1 | High when the address output equals 0x0001 |

## Verification
The bench steps mid-range values up, down and by zero. This separates the direction control from the step-size control. The all-ones and zero values expose any carry or borrow that fails to wrap. Values whose low six bits are all ones or all zero show whether a carry or borrow leaks past bit 5 under the limit control. A clear with the limit also active shows which of the two wins. The drive-back test loops the step result into the hold register through the bus, and then lets the bench drive the bus with the block released. The first shows that the bus carries the step result and not the held value; the second shows that no contention remains.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    localparam int ADDR_W    = 16;
    localparam int WRAP_BITS = 6;

    typedef struct packed {
        logic step_en;
        logic down;
        logic wrap_low;
        logic zero;
    } step_ctl_t;

    typedef enum logic [1:0] {
        SRC_DEFAULT = 2'b00,
        SRC_HOLD    = 2'b01,
        SRC_STEP    = 2'b10
    } out_src_t;

    function automatic out_src_t decode_src(input logic sel_step, input logic sel_hold);
        if (sel_step)      return SRC_STEP;
        else if (sel_hold) return SRC_HOLD;
        else               return SRC_DEFAULT;
    endfunction

endpackage

// File: rtl/addr_hold_reg.sv
module addr_hold_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (ld_en) q <= d;
    end

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> q == '0);
    a_r2_load_bus: assert property (@(posedge clk) disable iff (rst) ld_en |=> q == $past(d));
    a_r3_hold_value: assert property (@(posedge clk) disable iff (rst) !ld_en |=> $stable(q));

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper
    import addr_latch_pkg::*;
#(
    parameter int W   = 16,
    parameter int LIM = 6
) (
    input  logic [W-1:0] val,
    input  step_ctl_t    ctl,
    output logic [W-1:0] res
);

    localparam int LOW = (LIM < W) ? LIM : W;

    logic [W-1:0] delta;
    logic [W-1:0] full_res;
    logic [W-1:0] lim_res;

    assign delta    = {{(W-1){1'b0}}, ctl.step_en};
    assign full_res = ctl.down ? (val - delta) : (val + delta);

    generate
        if (LOW < W) begin : g_split
            logic [LOW-1:0] low_res;
            assign low_res = ctl.down ? (val[LOW-1:0] - delta[LOW-1:0])
                                      : (val[LOW-1:0] + delta[LOW-1:0]);
            assign lim_res = {val[W-1:LOW], low_res};
        end else begin : g_whole
            assign lim_res = full_res;
        end
    endgenerate

    always_comb begin
        if (ctl.zero)          res = '0;
        else if (ctl.wrap_low) res = lim_res;
        else                   res = full_res;
    end

endmodule

// File: rtl/addr_out_select.sv
module addr_out_select
    import addr_latch_pkg::*;
#(
    parameter int W = 16
) (
    input  out_src_t     src,
    input  logic [W-1:0] held,
    input  logic [W-1:0] stepped,
    output logic [W-1:0] addr,
    output logic         is_one
);

    always_comb begin
        case (src)
            SRC_STEP:    addr = stepped;
            SRC_HOLD:    addr = held;
            default:     addr = held;
        endcase
    end

    assign is_one = (addr == W'(1));

endmodule

// File: rtl/addr_latch_inc.sv
module addr_latch_inc
    import addr_latch_pkg::*;
#(
    parameter int W   = ADDR_W,
    parameter int LIM = WRAP_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic         bus_oe,
    input  logic         sel_step,
    input  logic         sel_hold,
    input  logic         step_en,
    input  logic         step_down,
    input  logic         wrap_low,
    input  logic         force_zero,
    inout  wire  [W-1:0] ibus,
    output logic [W-1:0] addr_out,
    output logic         addr_is_one
);

    logic [W-1:0] held;
    logic [W-1:0] stepped;
    step_ctl_t    ctl;
    out_src_t     src;

    assign ctl = '{step_en: step_en, down: step_down, wrap_low: wrap_low, zero: force_zero};
    assign src = decode_src(sel_step, sel_hold);

    addr_hold_reg #(.W(W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .ld_en (ld_en),
        .d     (ibus),
        .q     (held)
    );

    addr_stepper #(.W(W), .LIM(LIM)) u_step (
        .val (held),
        .ctl (ctl),
        .res (stepped)
    );

    addr_out_select #(.W(W)) u_sel (
        .src     (src),
        .held    (held),
        .stepped (stepped),
        .addr    (addr_out),
        .is_one  (addr_is_one)
    );

    assign ibus = bus_oe ? stepped : {W{1'bz}};

    a_r7_zero_wins: assert property (@(posedge clk) disable iff (rst)
        (force_zero && sel_step) |-> addr_out == '0);
    a_r8_raw_path: assert property (@(posedge clk) disable iff (rst)
        !sel_step |-> addr_out == held);
    a_r4_pass_through: assert property (@(posedge clk) disable iff (rst)
        (sel_step && !step_en && !force_zero) |-> addr_out == held);
    a_r5_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (sel_step && step_en && !step_down && !wrap_low && !force_zero && held == '1)
        |-> addr_out == '0);
    a_r9_bus_drive: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && ld_en) |=> held == $past(stepped));

endmodule

// File: tb/sim_addr_latch_inc.sv
`timescale 1ns/1ps
module sim_addr_latch_inc;

    typedef struct {
        logic [15:0] addr;
        logic        flag;
        logic        chk_bus;
        logic [15:0] bus;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, ld_en, bus_oe, sel_step, sel_hold, step_en, step_down, wrap_low, force_zero;
    logic [15:0] bus_drv;
    logic        bus_drv_en;
    wire  [15:0] ibus;
    logic [15:0] addr_out;
    logic        addr_is_one;

    assign ibus = bus_drv_en ? bus_drv : 16'hzzzz;

    addr_latch_inc u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .bus_oe(bus_oe),
        .sel_step(sel_step), .sel_hold(sel_hold), .step_en(step_en),
        .step_down(step_down), .wrap_low(wrap_low), .force_zero(force_zero),
        .ibus(ibus), .addr_out(addr_out), .addr_is_one(addr_is_one)
    );

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // Monitor: compares each expected item against the live outputs.
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (addr_out !== e.addr || addr_is_one !== e.flag) begin
                    n_bad++;
                    $display("FAIL %s: addr=%h flag=%b expected addr=%h flag=%b",
                             e.tag, addr_out, addr_is_one, e.addr, e.flag);
                end
                if (e.chk_bus && ibus !== e.bus) begin
                    n_bad++;
                    $display("FAIL %s: ibus=%h expected %h", e.tag, ibus, e.bus);
                end
            end
        end
    end

    task automatic expect_out(input logic [15:0] a, input logic cb, input logic [15:0] b,
                              input string tag);
        exp_t e;
        #1;
        e.addr = a; e.flag = (a == 16'h0001); e.chk_bus = cb; e.bus = b; e.tag = tag;
        q.push_back(e);
        #0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v);
        bus_drv = v; bus_drv_en = 1; ld_en = 1; bus_oe = 0;
        tick();
        ld_en = 0;
    endtask

    task automatic stepc(input logic en, input logic dn, input logic lim, input logic z);
        step_en = en; step_down = dn; wrap_low = lim; force_zero = z;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5 * 20000);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        rst = 1; ld_en = 0; bus_oe = 0; sel_step = 0; sel_hold = 0;
        stepc(0, 0, 0, 0);
        bus_drv = 16'h7777; bus_drv_en = 1;
        @(negedge clk);
        tick();
        rst = 0;
        expect_out(16'h0000, 0, 0, "R1 reset value");

        load(16'h1234);
        sel_step = 1; stepc(1, 0, 0, 0);
        expect_out(16'h1235, 0, 0, "R2 R4 load then add");
        stepc(1, 1, 0, 0);
        expect_out(16'h1233, 0, 0, "R4 subtract");
        stepc(0, 0, 0, 0);
        expect_out(16'h1234, 0, 0, "R4 zero step");

        bus_drv = 16'h5555; ld_en = 0;
        tick();
        sel_step = 0;
        expect_out(16'h1234, 0, 0, "R3 hold with ld_en low");

        load(16'hFFFF);
        sel_step = 1; stepc(1, 0, 0, 0);
        expect_out(16'h0000, 0, 0, "R5 FFFF+1");
        stepc(1, 1, 0, 0);
        expect_out(16'hFFFE, 0, 0, "R5 FFFF-1");
        load(16'h0000);
        expect_out(16'hFFFF, 0, 0, "R5 0000-1");
        stepc(1, 0, 0, 0);
        expect_out(16'h0001, 0, 0, "R10 flag from step result");

        load(16'h12BF);
        stepc(1, 0, 1, 0);
        expect_out(16'h1280, 0, 0, "R6 low carry contained");
        load(16'h12C0);
        stepc(1, 1, 1, 0);
        expect_out(16'h12FF, 0, 0, "R6 low borrow contained");
        load(16'h12C5);
        stepc(1, 0, 1, 0);
        expect_out(16'h12C6, 0, 0, "R6 plain low step");

        stepc(1, 0, 1, 1);
        expect_out(16'h0000, 0, 0, "R7 clear over limit");
        stepc(1, 1, 0, 1);
        expect_out(16'h0000, 0, 0, "R7 clear over subtract");
        sel_step = 0;
        expect_out(16'h12C5, 0, 0, "R8 both selects low");
        sel_hold = 1;
        expect_out(16'h12C5, 0, 0, "R8 raw select");
        sel_hold = 0;

        load(16'h0001);
        stepc(1, 0, 0, 0);
        expect_out(16'h0001, 0, 0, "R10 flag on raw value");
        sel_step = 1;
        expect_out(16'h0002, 0, 0, "R10 flag drops");

        load(16'h00FE);
        bus_drv_en = 0; bus_oe = 1; stepc(1, 0, 0, 0);
        expect_out(16'h00FF, 1, 16'h00FF, "R9 drive step result");
        ld_en = 1;
        tick();
        ld_en = 0;
        expect_out(16'h0100, 1, 16'h0100, "R9 loop back via bus");
        sel_step = 0;
        expect_out(16'h00FF, 0, 0, "R9 looped value held");
        bus_oe = 0; bus_drv = 16'hABCD; bus_drv_en = 1;
        #1;
        expect_out(16'h00FF, 1, 16'hABCD, "R9 bus released");
        load(16'hABCD);
        expect_out(16'hABCD, 0, 0, "R9 external load after release");

        rst = 1;
        tick();
        rst = 0;
        expect_out(16'h0000, 0, 0, "R1 reset after activity");

        tick();
        finish_run();
    end

endmodule